// File: doc/BRIEF.md
# Supply-Fail Write-Inhibit Controller

This block decides whether a memory interface may accept accesses, based on how healthy the supply is. Two digital comparator flags arrive from analog circuitry outside the block. One says the supply is above the upper power-fail level. The other says the supply is above the lower power-fail level. A one-cycle microsecond strobe, taken from the system clock, is the only time base.

The block has three outputs. One enables input recognition. One forces the data outputs to high impedance. One inhibits writes. The last two are always the inverse of the enable.

When the supply sags between the two levels, the block keeps running for a bounded window and then protects. If the supply falls through both levels quickly, protection may be postponed for a short fixed interval after the lower crossing. If the fall is slow, protection is immediate.

After a fall, the block recovers only when both flags have stayed high for a timed count. The block leaves reset in the protected state. It reaches normal operation only through this recovery count.

Top module: `supply_guard`

## Requirements
- R1: While reset is held, and right after it is released, `inputs_en` is 0 and both `outputs_hiz` and `write_inhibit` are 1.
- R2: In every cycle, `outputs_hiz` and `write_inhibit` both equal the inverse of `inputs_en`.
- R3: While enabled with both flags high, a drop of `above_lo` (together with `above_hi`) disables the block in the cycle after the drop is sampled.
- R4: While enabled, if only `above_hi` drops, the block stays enabled. It disables on the WP_US-th tick counted after the drop.
- R5: If `above_hi` returns while the block is in that sag window, the block stays enabled. A later sag starts a new, full WP_US window.
- R6: If `above_lo` drops after fewer than FAST_US ticks of sag, the fall counts as fast. The block stays enabled for LATE_US-1 more ticks and disables on the LATE_US-th tick.
- R7: If `above_lo` drops after FAST_US or more ticks of sag, the block disables in the next cycle.
- R8: While disabled, once both flags are high, the block enables on the REC_US-th tick counted after recovery starts.
- R9: If either flag drops during recovery, the block stays disabled. The recovery count restarts from zero when both flags are high again.
- R10: While disabled with `above_lo` high and `above_hi` low, the block stays disabled no matter how many ticks arrive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| us_tick | input | 1 | One-cycle strobe once per microsecond |
| above_hi | input | 1 | Supply is above the upper power-fail level |
| above_lo | input | 1 | Supply is above the lower power-fail level |
| inputs_en | output | 1 | Memory inputs are recognized |
| outputs_hiz | output | 1 | Force memory data outputs to high impedance |
| write_inhibit | output | 1 | Block all memory writes |

## Verification
Two things can fall in the same cycle: the lower-level crossing and the end of the sag window. The fast/slow decision also depends on which one is seen first. To provoke this, the bench sweeps the sag length in ticks across every value from zero up to one past the protection window, and drops the lower flag at each length. For each length it computes in arithmetic whether protection was already due, postponed by the fast-fall interval, or immediate. A second sweep interrupts recovery at each possible tick, so the restart and the completion boundary both get judged.

// File: rtl/supply_guard.sv
module supply_guard #(
  parameter int REC_US  = 20,
  parameter int WP_US   = 500,
  parameter int FAST_US = 100,
  parameter int LATE_US = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic us_tick,
  input  logic above_hi,
  input  logic above_lo,
  output logic inputs_en,
  output logic outputs_hiz,
  output logic write_inhibit
);
  localparam int M1   = (WP_US > REC_US) ? WP_US : REC_US;
  localparam int CMAX = (M1 > LATE_US) ? M1 : LATE_US;
  localparam int CW   = $clog2(CMAX + 1);

  typedef enum logic [2:0] {S_NORM, S_SAG, S_LATE, S_PROT, S_REC} st_t;

  st_t           st, st_n;
  logic [CW-1:0] cnt, cnt_n;
  logic          good;

  assign good = above_hi & above_lo;

  always_comb begin
    st_n  = st;
    cnt_n = cnt;
    case (st)
      S_NORM: begin
        cnt_n = '0;
        if (!above_lo)      st_n = S_PROT;
        else if (!above_hi) st_n = S_SAG;
      end
      S_SAG: begin
        if (!above_lo) begin
          cnt_n = '0;
          st_n  = (cnt < CW'(FAST_US)) ? S_LATE : S_PROT;
        end else if (above_hi) begin
          cnt_n = '0;
          st_n  = S_NORM;
        end else if (us_tick) begin
          if (cnt == CW'(WP_US - 1)) begin
            cnt_n = '0;
            st_n  = S_PROT;
          end else cnt_n = cnt + 1'b1;
        end
      end
      S_LATE: begin
        if (us_tick) begin
          if (cnt == CW'(LATE_US - 1)) begin
            cnt_n = '0;
            st_n  = S_PROT;
          end else cnt_n = cnt + 1'b1;
        end
      end
      S_PROT: begin
        cnt_n = '0;
        if (good) st_n = S_REC;
      end
      S_REC: begin
        if (!good) begin
          cnt_n = '0;
          st_n  = S_PROT;
        end else if (us_tick) begin
          if (cnt == CW'(REC_US - 1)) begin
            cnt_n = '0;
            st_n  = S_NORM;
          end else cnt_n = cnt + 1'b1;
        end
      end
      default: begin
        cnt_n = '0;
        st_n  = S_PROT;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st  <= S_PROT;
      cnt <= '0;
    end else begin
      st  <= st_n;
      cnt <= cnt_n;
    end
  end

  assign inputs_en     = (st == S_NORM) | (st == S_SAG) | (st == S_LATE);
  assign outputs_hiz   = ~inputs_en;
  assign write_inhibit = ~inputs_en;
endmodule

// File: rtl/supply_guard_chk.sv
module supply_guard_chk #(
  parameter int WP_US   = 500,
  parameter int LATE_US = 20
) (
  input logic clk,
  input logic rst_n,
  input logic us_tick,
  input logic above_hi,
  input logic above_lo,
  input logic inputs_en,
  input logic outputs_hiz,
  input logic write_inhibit
);
  int sag_ticks, low_ticks;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sag_ticks <= 0;
      low_ticks <= 0;
    end else begin
      if (inputs_en && !above_hi) sag_ticks <= sag_ticks + (us_tick ? 1 : 0);
      else sag_ticks <= 0;
      if (inputs_en && !above_lo) low_ticks <= low_ticks + (us_tick ? 1 : 0);
      else low_ticks <= 0;
    end
  end

  a_r1_reset_protects: assert property (@(posedge clk) !rst_n |=> !inputs_en);
  a_r2_pins_agree: assert property (@(posedge clk) disable iff (!rst_n)
    (outputs_hiz == !inputs_en) && (write_inhibit == !inputs_en));
  a_r8_enable_needs_good: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(inputs_en) |-> $past(above_hi && above_lo));
  a_r9_bad_keeps_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!inputs_en && !(above_hi && above_lo)) |=> !inputs_en);
  a_r4_sag_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    sag_ticks <= WP_US);
  a_r6_late_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    low_ticks <= LATE_US);
endmodule

bind supply_guard supply_guard_chk #(.WP_US(WP_US), .LATE_US(LATE_US)) u_chk (
  .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .above_hi(above_hi),
  .above_lo(above_lo), .inputs_en(inputs_en), .outputs_hiz(outputs_hiz),
  .write_inhibit(write_inhibit)
);

// File: tb/supply_guard_bench.sv
`timescale 1ns/1ps
module supply_guard_bench;
  localparam int REC = 5, WP = 12, FAST = 6, LATE = 3;

  logic clk = 0, rst_n = 0, us_tick = 0, above_hi = 0, above_lo = 0;
  logic inputs_en, outputs_hiz, write_inhibit;
  int checks = 0, failures = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  supply_guard #(.REC_US(REC), .WP_US(WP), .FAST_US(FAST), .LATE_US(LATE)) u_supply_guard (
    .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .above_hi(above_hi),
    .above_lo(above_lo), .inputs_en(inputs_en), .outputs_hiz(outputs_hiz),
    .write_inhibit(write_inhibit));

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic tick();
    us_tick = 1; step(); us_tick = 0; step();
  endtask

  task automatic chk(input logic exp_en, input string tag);
    checks++;
    if (inputs_en !== exp_en || outputs_hiz !== !exp_en || write_inhibit !== !exp_en) begin
      failures++;
      $display("FAIL %s: en/hiz/inh=%b%b%b expected %b%b%b", tag,
               inputs_en, outputs_hiz, write_inhibit, exp_en, !exp_en, !exp_en);
    end
  endtask

  task automatic go_normal();
    above_hi = 1; above_lo = 1; step();
    for (int i = 0; i < REC; i++) tick();
    chk(1'b1, "R8 recovery complete");
  endtask

  task automatic go_prot();
    above_hi = 0; above_lo = 0; step(); step();
  endtask

  initial begin
    repeat (3) step();
    chk(1'b0, "R1 in reset");
    rst_n = 1; step();
    chk(1'b0, "R1 after reset");

    above_lo = 1; above_hi = 0;
    for (int i = 0; i < 3 * REC; i++) tick();
    chk(1'b0, "R10 only lower flag");

    go_normal();
    above_lo = 0; above_hi = 0; step();
    chk(1'b0, "R3 direct drop");

    for (int t = 0; t <= WP + 1; t++) begin
      go_normal();
      above_hi = 0; step();
      for (int i = 1; i <= t; i++) begin
        tick();
        chk((i < WP) ? 1'b1 : 1'b0, "R4 sag window");
      end
      above_lo = 0; step();
      if (t >= WP) chk(1'b0, "R4 already protected");
      else if (t < FAST) begin
        chk(1'b1, "R6 fast fall postponed");
        for (int i = 1; i <= LATE; i++) begin
          tick();
          chk((i < LATE) ? 1'b1 : 1'b0, "R6 late interval");
        end
      end else chk(1'b0, "R7 slow fall immediate");
      go_prot();
    end

    go_normal();
    above_hi = 0; step();
    for (int i = 0; i < WP - 2; i++) tick();
    above_hi = 1; step();
    chk(1'b1, "R5 sag cancelled");
    above_hi = 0; step();
    for (int i = 1; i <= WP; i++) begin
      tick();
      chk((i < WP) ? 1'b1 : 1'b0, "R5 fresh window");
    end
    go_prot();

    for (int k = 0; k < REC; k++) begin
      above_hi = 1; above_lo = 1; step();
      for (int i = 0; i < k; i++) tick();
      chk(1'b0, "R8 not yet");
      if (k % 2 == 0) above_hi = 0; else above_lo = 0;
      step(); tick();
      chk(1'b0, "R9 drop in recovery");
      above_hi = 1; above_lo = 1; step();
      for (int i = 1; i <= REC; i++) begin
        tick();
        chk((i < REC) ? 1'b0 : 1'b1, "R9 restart count");
      end
      go_prot();
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule